// File: doc/BRIEF.md
# Boot Failure Supervisor with Bounded Retry

This board-side supervisor watches three status pins of a processor: its hard-reset output, its reset-request output and its asleep indicator. When the processor raises a reset request, the supervisor decides what kind of failure it is. A request that arrives while the asleep indicator is still high means the boot image in the serial PROM is bad. A request that arrives after asleep has dropped is a request made at runtime. For a boot-image failure, the supervisor also records the hard-reset pin level. A low level points to a failure while the configuration word was loading. A high level points to a failure in the later preboot command phase.

The supervisor retries a failed boot with a fresh power-on reset pulse. It gives up after a fixed number of attempts and then holds a failed state with reset released. A debug input stops requests from being turned into resets, so an external debugger can still reach the processor's error registers. The sticky LEDs, the gave-up flag and the attempt count tell a technician which case occurred. All three pins are synchronised and glitch-filtered before use.

Top module: `boot_sup_top`

## Requirements
- R1: While the board reset `rst_n` is low, `poreset_n_out` is driven low. During that time both LEDs, `cfg_word_fault` and `gave_up` read 0, and `attempt_count` reads 0.
- R2: Each boot attempt, including the first after board reset, drives `poreset_n_out` low for at least POR_LOW_CYC cycles and at most POR_LOW_CYC+1 cycles. Each boot attempt adds one to `attempt_count`. A runtime-triggered reset pulse lasts exactly POR_LOW_CYC cycles.
- R3: A reset request, meaning a falling edge of the filtered `rst_req_n_in`, that arrives while filtered `asleep_in` is 1 does three things: it sets `image_fault_led`, it starts a new boot attempt, and it leaves `runtime_fault_led` unchanged.
- R4: On a boot-image failure, `cfg_word_fault` takes the inverse of the filtered `hreset_n_in` level. It reads 1 when hard reset was still low, which marks a configuration-word failure. It reads 0 when hard reset was high, which marks a preboot-phase failure.
- R5: A reset request that arrives while filtered `asleep_in` is 0 does three things: it sets `runtime_fault_led`, it issues one reset pulse, and it leaves `attempt_count` and `image_fault_led` unchanged.
- R6: A boot-image failure seen when `attempt_count` equals MAX_ATTEMPTS (16) sets `gave_up`. After that no further pulse is issued, `poreset_n_out` stays high and `attempt_count` stays at 16, even if more requests arrive.
- R7: While `debug_hold` is 1, a reset request produces no reset pulse and leaves `attempt_count` unchanged. The fault LEDs are still set as in R3 and R5.
- R8: A low excursion on `rst_req_n_in` that is shorter than FILT_LEN cycles is not treated as a request. No pulse results and `attempt_count` is unchanged.
- R9: A one-cycle `clear` pulse does two things. It clears both LEDs, `cfg_word_fault`, `gave_up` and `attempt_count`. It then starts a new boot attempt, so `attempt_count` returns to 1.
- R10: The fault LEDs are sticky. They stay set across later retries and later requests of the other class, and only `clear` or board reset removes them.
- R11: When the filtered request edge and the filtered fall of asleep land in the same cycle, the request is classed as runtime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Board power-up reset, active low |
| clear | input | 1 | Clears count and flags and restarts the boot |
| debug_hold | input | 1 | When 1, requests never produce resets |
| hreset_n_in | input | 1 | Processor hard-reset pin, active low |
| rst_req_n_in | input | 1 | Processor reset-request pin, active low |
| asleep_in | input | 1 | Processor asleep pin, high until the system is ready |
| poreset_n_out | output | 1 | Power-on reset drive to the processor, active low |
| image_fault_led | output | 1 | Sticky boot-image failure indicator |
| runtime_fault_led | output | 1 | Sticky runtime request indicator |
| cfg_word_fault | output | 1 | Last image failure occurred with hard reset low |
| gave_up | output | 1 | Retry limit reached, supervisor halted |
| attempt_count | output | CNT_W (5) | Number of boot attempts made |

## Verification
Two functions can fall in the same cycle: classifying a request and tracking the fall of the asleep pin. The bench drives the asleep pin low and the request pin low on the same clock edge. Both pins pass through identical synchroniser and filter stages, so the request edge and the asleep fall reach the classifier together. The result must be a runtime classification, a pulse of exactly POR_LOW_CYC cycles, no image LED and an unchanged attempt count.

// File: rtl/boot_sup_pkg.sv
package boot_sup_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_PULSE,
    ST_WATCH,
    ST_HOLD,
    ST_GAVEUP
  } sup_state_e;

  typedef enum logic [1:0] {
    FK_NONE,
    FK_IMAGE,
    FK_RUNTIME
  } fault_kind_e;

  // A request edge is a boot-image fault while the device still sleeps.
  function automatic fault_kind_e classify_req(input logic req_edge, input logic asleep_lvl);
    if (!req_edge) return FK_NONE;
    return asleep_lvl ? FK_IMAGE : FK_RUNTIME;
  endfunction

  function automatic logic limit_hit(input int attempts, input int max_attempts);
    return attempts >= max_attempts;
  endfunction

  function automatic int next_count(input int attempts, input int max_attempts);
    return (attempts < max_attempts) ? attempts + 1 : attempts;
  endfunction

endpackage

// File: rtl/pin_filter.sv
module pin_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fell
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   fell_q;
  logic                   s;

  assign s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= RST_VAL;
      fell_q  <= 1'b0;
    end else if (s == level_q) begin
      run_q  <= '0;
      fell_q <= 1'b0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      run_q   <= '0;
      level_q <= s;
      fell_q  <= level_q & ~s;
    end else begin
      run_q  <= run_q + 1'b1;
      fell_q <= 1'b0;
    end
  end

  assign level = level_q;
  assign fell  = fell_q;

  // R8: the filtered level only ever moves to the value the synchroniser held
  a_r8_level_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(s) == level_q));

endmodule

// File: rtl/por_pulse.sv
module por_pulse #(
  parameter int LOW_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LOW_CYC + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= CW'(LOW_CYC);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign done = (left_q == CW'(1));

endmodule

// File: rtl/boot_sup_top.sv
module boot_sup_top
  import boot_sup_pkg::*;
#(
  parameter int POR_LOW_CYC  = 125000,
  parameter int MAX_ATTEMPTS = 16,
  parameter int FILT_LEN     = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             debug_hold,
  input  logic             hreset_n_in,
  input  logic             rst_req_n_in,
  input  logic             asleep_in,
  output logic             poreset_n_out,
  output logic             image_fault_led,
  output logic             runtime_fault_led,
  output logic             cfg_word_fault,
  output logic             gave_up,
  output logic [CNT_W-1:0] attempt_count
);
  localparam int NPIN = 3;  // 0 hard reset, 1 reset request, 2 asleep
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b111;

  logic [NPIN-1:0] pins_raw, levels, fells;
  assign pins_raw = {asleep_in, rst_req_n_in, hreset_n_in};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RST_VAL    (PIN_IDLE[g])
    ) i_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins_raw[g]),
      .level(levels[g]),
      .fell (fells[g])
    );
  end

  logic [1:0] unused_fells;
  assign unused_fells = {fells[2], fells[0]};

  // Named internal events for the assertions
  logic        hreset_f, asleep_f, req_evt, watching, pulse_done, launch;
  fault_kind_e kind;
  assign hreset_f = levels[0];
  assign asleep_f = levels[2];
  assign req_evt  = fells[1];

  sup_state_e state_q, state_d;
  logic [CNT_W-1:0] count_q;
  logic img_q, rt_q, cfg_q;

  assign watching = (state_q == ST_WATCH);
  assign kind     = classify_req(req_evt && watching, asleep_f);

  por_pulse #(.LOW_CYC(POR_LOW_CYC)) i_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .start(launch),
    .done (pulse_done)
  );

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    unique case (state_q)
      ST_START: begin
        launch  = 1'b1;
        state_d = ST_PULSE;
      end
      ST_PULSE: if (pulse_done) state_d = ST_WATCH;
      ST_WATCH: begin
        if (kind != FK_NONE) begin
          if (debug_hold) begin
            state_d = ST_HOLD;
          end else if (kind == FK_RUNTIME) begin
            launch  = 1'b1;
            state_d = ST_PULSE;
          end else if (limit_hit(int'(count_q), MAX_ATTEMPTS)) begin
            state_d = ST_GAVEUP;
          end else begin
            state_d = ST_START;
          end
        end
      end
      default: state_d = state_q;
    endcase
    if (clear) begin
      state_d = ST_START;
      launch  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      count_q <= '0;
      img_q   <= 1'b0;
      rt_q    <= 1'b0;
      cfg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clear) begin
        count_q <= '0;
        img_q   <= 1'b0;
        rt_q    <= 1'b0;
        cfg_q   <= 1'b0;
      end else begin
        if (state_q == ST_START)
          count_q <= CNT_W'(next_count(int'(count_q), MAX_ATTEMPTS));
        if (kind == FK_IMAGE) begin
          img_q <= 1'b1;
          cfg_q <= ~hreset_f;
        end
        if (kind == FK_RUNTIME) rt_q <= 1'b1;
      end
    end
  end

  assign poreset_n_out     = !((state_q == ST_START) || (state_q == ST_PULSE));
  assign image_fault_led   = img_q;
  assign runtime_fault_led = rt_q;
  assign cfg_word_fault    = cfg_q;
  assign gave_up           = (state_q == ST_GAVEUP);
  assign attempt_count     = count_q;

  // Checker counter: length of the current low phase of the reset drive
  int unsigned low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!poreset_n_out) low_run <= low_run + 1;
    else low_run <= 0;
  end

  // R2: every released pulse lasted at least the configured width
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poreset_n_out) |-> (low_run >= POR_LOW_CYC));

  // R6: the attempt counter never passes the limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(attempt_count) <= MAX_ATTEMPTS);

  // R6: once given up, reset stays released
  a_r6_gave_up_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    gave_up |-> poreset_n_out);

  // R7: in debug mode a request never pulls reset low
  a_r7_debug_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (watching && req_evt && debug_hold && !clear) |=> poreset_n_out);

  // R5: a runtime request leaves the attempt count alone
  a_r5_runtime_count: assert property (@(posedge clk) disable iff (!rst_n)
    (watching && req_evt && !asleep_f && !clear) |=> $stable(attempt_count));

  // R3: a request while asleep lights the image LED next cycle
  a_r3_image_led: assert property (@(posedge clk) disable iff (!rst_n)
    (watching && req_evt && asleep_f && !clear) |=> image_fault_led);

endmodule

// File: tb/test_boot_sup_top.sv
module test_boot_sup_top;
  localparam int POR  = 20;
  localparam int MAXA = 16;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clear = 1'b0, debug_hold = 1'b0;
  logic hreset_n_in = 1'b1, rst_req_n_in = 1'b1, asleep_in = 1'b1;
  logic poreset_n_out, image_fault_led, runtime_fault_led, cfg_word_fault, gave_up;
  logic [4:0] attempt_count;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  boot_sup_top #(
    .POR_LOW_CYC (POR),
    .MAX_ATTEMPTS(MAXA),
    .FILT_LEN    (FILT),
    .SYNC_STAGES (2)
  ) i_boot_sup_top (
    .clk              (clk),
    .rst_n            (rst_n),
    .clear            (clear),
    .debug_hold       (debug_hold),
    .hreset_n_in      (hreset_n_in),
    .rst_req_n_in     (rst_req_n_in),
    .asleep_in        (asleep_in),
    .poreset_n_out    (poreset_n_out),
    .image_fault_led  (image_fault_led),
    .runtime_fault_led(runtime_fault_led),
    .cfg_word_fault   (cfg_word_fault),
    .gave_up          (gave_up),
    .attempt_count    (attempt_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_pulse(output bit seen, output int len);
    seen = 1'b0;
    len  = 0;
    for (int i = 0; i < 60 && poreset_n_out; i++) @(negedge clk);
    if (!poreset_n_out) begin
      seen = 1'b1;
      while (!poreset_n_out && len < 1000) begin
        len++;
        @(negedge clk);
      end
    end
  endtask

  task automatic request(output bit seen, output int len);
    cycles(12);
    rst_req_n_in = 1'b0;
    measure_pulse(seen, len);
    rst_req_n_in = 1'b1;
  endtask

  task automatic t_reset;
    bit seen; int len;
    cycles(5);
    chk("R1", "poreset low in reset", poreset_n_out, 0);
    chk("R1", "leds in reset", {image_fault_led, runtime_fault_led, cfg_word_fault}, 0);
    chk("R1", "gave_up in reset", gave_up, 0);
    chk("R1", "count in reset", attempt_count, 0);
    rst_n = 1'b1;
    measure_pulse(seen, len);
    chk("R2", "first pulse seen", seen, 1);
    chk("R2", "first pulse width ok", int'(len >= POR && len <= POR + 1), 1);
    chk("R2", "count after first attempt", attempt_count, 1);
  endtask

  task automatic t_cfg_fault;
    bit seen; int len;
    hreset_n_in = 1'b0; asleep_in = 1'b1;
    request(seen, len);
    chk("R3", "retry pulse", seen, 1);
    chk("R2", "retry width ok", int'(len >= POR && len <= POR + 1), 1);
    chk("R3", "image led", image_fault_led, 1);
    chk("R3", "runtime led untouched", runtime_fault_led, 0);
    chk("R4", "cfg word fault with hreset low", cfg_word_fault, 1);
    chk("R2", "count after retry", attempt_count, 2);
  endtask

  task automatic t_preboot_fault;
    bit seen; int len;
    hreset_n_in = 1'b1;
    request(seen, len);
    chk("R3", "retry pulse", seen, 1);
    chk("R4", "preboot fault with hreset high", cfg_word_fault, 0);
    chk("R10", "image led sticky", image_fault_led, 1);
    chk("R2", "count after second retry", attempt_count, 3);
  endtask

  task automatic t_runtime;
    bit seen; int len;
    asleep_in = 1'b0;
    request(seen, len);
    chk("R5", "runtime pulse", seen, 1);
    chk("R2", "runtime pulse width", len, POR);
    chk("R5", "runtime led", runtime_fault_led, 1);
    chk("R5", "count unchanged", attempt_count, 3);
    chk("R10", "image led kept", image_fault_led, 1);
    asleep_in = 1'b1;
  endtask

  task automatic t_glitch;
    bit seen; int len;
    cycles(12);
    rst_req_n_in = 1'b0;
    cycles(FILT - 2);
    rst_req_n_in = 1'b1;
    measure_pulse(seen, len);
    chk("R8", "glitch gives no pulse", seen, 0);
    chk("R8", "glitch leaves count", attempt_count, 3);
  endtask

  task automatic t_clear;
    bit seen; int len;
    cycles(2);
    clear = 1'b1;
    cycles(1);
    clear = 1'b0;
    measure_pulse(seen, len);
    chk("R9", "clear restarts boot", seen, 1);
    chk("R9", "count after clear", attempt_count, 1);
    chk("R9", "leds after clear", {image_fault_led, runtime_fault_led, cfg_word_fault}, 0);
    chk("R9", "gave_up after clear", gave_up, 0);
  endtask

  task automatic t_coincide;
    bit seen; int len;
    asleep_in = 1'b1;
    cycles(12);
    asleep_in = 1'b0;
    rst_req_n_in = 1'b0;
    measure_pulse(seen, len);
    rst_req_n_in = 1'b1;
    chk("R11", "coincident pulse", seen, 1);
    chk("R11", "coincident width", len, POR);
    chk("R11", "classed runtime", runtime_fault_led, 1);
    chk("R11", "not image", image_fault_led, 0);
    chk("R11", "count unchanged", attempt_count, 1);
    asleep_in = 1'b1;
    cycles(12);
  endtask

  task automatic t_debug;
    bit seen; int len;
    debug_hold = 1'b1;
    request(seen, len);
    chk("R7", "debug gives no pulse", seen, 0);
    chk("R7", "debug still flags image", image_fault_led, 1);
    chk("R7", "debug leaves count", attempt_count, 1);
    debug_hold = 1'b0;
  endtask

  task automatic t_giveup;
    bit seen; int len;
    for (int k = 0; k < MAXA - 1; k++) begin
      request(seen, len);
      chk("R6", "retry below limit", seen, 1);
      chk("R6", "count climbs", attempt_count, k + 2);
    end
    request(seen, len);
    chk("R6", "no pulse at limit", seen, 0);
    chk("R6", "gave_up set", gave_up, 1);
    chk("R6", "count held", attempt_count, MAXA);
    request(seen, len);
    chk("R6", "still quiet after give-up", seen, 0);
    chk("R6", "count still held", attempt_count, MAXA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cfg_fault();
    t_preboot_fault();
    t_runtime();
    t_glitch();
    t_clear();
    t_coincide();
    t_debug();
    t_clear();
    t_giveup();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule